// File: doc/BRIEF.md
# SDRAM Control-Pin Command Decoder with Power-Mode Tracking

This block sits on the device side of an SDRAM interface. On every rising clock edge it samples the control pins and sorts the sampled pattern into a command class. The classes are deselect, no-operation, auto refresh, entry into and exit from self refresh, and entry into and exit from the two clock-enable-low states. It keeps a register holding the operating mode: normal, clock-suspended, powered-down or self-refreshing. From that register it drives an internal clock-enable and an enable for the input and output buffers.

A low clock-enable is read in one of two ways, depending on the state the array reports. During a data burst it freezes the internal clock and keeps all state. With no burst running it turns the buffers off. The matching exit depends on which state was entered. In self refresh the block ignores every pin except clock-enable until a well-formed exit pattern arrives.

The block also turns each lane of the data-mask input into a write mask or a read output-drive enable. All outputs are registered and show the pins sampled at the previous edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, the outputs hold these values: `mode` = 0 (normal), `cmd` = 0 (no-operation), `intClkEn` = 1, `bufEn` = 1, `illegalCmd` = 0, and both mask vectors are all zero.
- R2: In normal mode with `cke` high, `csN` high gives `cmd` = 1 (deselect) whatever the values on `rasN`/`casN`/`weN`. With `csN` low, `rasN`/`casN`/`weN` all high gives `cmd` = 0 (no-operation), and any pattern not decoded elsewhere gives `cmd` = 10. None of these changes `mode`.
- R3: In normal mode, `cke` high in this cycle and the previous one, `csN` low, `rasN` low, `casN` low and `weN` high give `cmd` = 2 (auto refresh). `illegalCmd` is raised in the same cycle as that `cmd` if `banksIdle` was low, and is held low otherwise.
- R4: In normal mode, `cke` low with `csN` low and the R3 pin pattern gives `cmd` = 3 and `mode` = 3 (self refresh). While `cke` stays low in that mode, every other pin is ignored: `cmd` = 9 (hold) and `mode` stays 3.
- R5: In self refresh, `cke` high together with `csN` high, or with `rasN`/`casN`/`weN` all high, gives `cmd` = 4 and `mode` = 0. `cke` high with any other pattern raises `illegalCmd`, gives `cmd` = 9 and leaves `mode` at 3.
- R6: In normal mode, `cke` low while `burstActive` is high (and the pins do not match R4) gives `cmd` = 5 and `mode` = 1 (suspended). `intClkEn` is low from the next output cycle on, while `bufEn` stays high. With `cke` high while suspended, the output is `cmd` = 8 and `mode` = 0, and `intClkEn` returns high. While `cke` stays low the output is `cmd` = 9.
- R7: In normal mode, `cke` low with `burstActive` low (and the pins not matching R4) gives `cmd` = 6 and `mode` = 2 (powered down). In that mode, and in self refresh, `intClkEn` and `bufEn` are both low. With `cke` high while powered down, the output is `cmd` = 7 and `mode` = 0, and both enables return high.
- R8: The mask outputs update only on edges where the mode register read normal. For each lane, when `burstActive` and `burstWrite` are both high, `wrMask` takes that lane's `dqm` value. When `burstActive` is high and `burstWrite` is low, `rdDrive` takes the inverse of that lane's `dqm`. A lane with no burst of the matching kind reads 0. In any other mode both vectors hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| dqm | input | LANES | Per-lane data mask pin |
| banksIdle | input | 1 | All banks precharged |
| burstActive | input | 1 | A data burst is in progress |
| burstWrite | input | 1 | The running burst is a write |
| cmd | output | 4 | Registered command class |
| mode | output | 2 | Operating mode |
| illegalCmd | output | 1 | Pulse flagging a rejected command |
| intClkEn | output | 1 | Internal clock enable |
| bufEn | output | 1 | Input/output buffer enable |
| wrMask | output | LANES | Per-lane write mask |
| rdDrive | output | LANES | Per-lane read output-drive enable |

## Verification
The bench first targets the shared clock-enable-low pattern. If the burst flag is decoded the wrong way round, the design enters power-down in the middle of a burst, and the buffer enable drops too early or never drops. Self-refresh exit is tried with both legal patterns and with illegal ones. A wrong decoder either leaves self refresh on garbage or never leaves it. Auto refresh is tried with the banks busy, where a missing check leaves the illegal flag silent. Masks are then driven with changing values while the device sits in a low mode. A design that keeps capturing them there shows lanes that change when they should be frozen.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_SUSPEND = 2'd1,
    MODE_PDOWN   = 2'd2,
    MODE_SREF    = 2'd3
  } opMode_t;

  typedef enum logic [3:0] {
    CMD_NOP        = 4'd0,
    CMD_DESEL      = 4'd1,
    CMD_AREF       = 4'd2,
    CMD_SREF_ENTER = 4'd3,
    CMD_SREF_EXIT  = 4'd4,
    CMD_SUSP_ENTER = 4'd5,
    CMD_PD_ENTER   = 4'd6,
    CMD_PD_EXIT    = 4'd7,
    CMD_SUSP_EXIT  = 4'd8,
    CMD_HOLD       = 4'd9,
    CMD_OTHER      = 4'd10
  } cmdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureDqm; // internal clock ran this cycle
    logic clkRun;     // next mode lets the clock run
    logic bufOn;      // next mode keeps buffers powered
  } dpStrobe_t;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      rasN,
  input  logic      casN,
  input  logic      weN,
  input  logic      cke,
  input  logic      banksIdle,
  input  logic      burstActive,
  output opMode_t   modeQ,
  output cmdKind_t  cmdQ,
  output logic      illegalQ,
  output dpStrobe_t strobe
);

  logic     ckePrevQ;
  opMode_t  modeD;
  cmdKind_t cmdD;
  logic     illegalD;
  logic     refPat;
  logic     idlePat;

  assign refPat  = !rasN && !casN && weN;
  assign idlePat = rasN && casN && weN;

  always_comb begin
    modeD    = modeQ;
    cmdD     = CMD_HOLD;
    illegalD = 1'b0;
    case (modeQ)
      MODE_NORMAL: begin
        if (!cke) begin
          if (!csN && refPat) begin
            modeD = MODE_SREF;
            cmdD  = CMD_SREF_ENTER;
          end else if (burstActive) begin
            modeD = MODE_SUSPEND;
            cmdD  = CMD_SUSP_ENTER;
          end else begin
            modeD = MODE_PDOWN;
            cmdD  = CMD_PD_ENTER;
          end
        end else if (csN) begin
          cmdD = CMD_DESEL;
        end else if (refPat && ckePrevQ) begin
          cmdD     = CMD_AREF;
          illegalD = !banksIdle;
        end else if (idlePat) begin
          cmdD = CMD_NOP;
        end else begin
          cmdD = CMD_OTHER;
        end
      end
      MODE_SUSPEND: begin
        if (cke) begin
          modeD = MODE_NORMAL;
          cmdD  = CMD_SUSP_EXIT;
        end
      end
      MODE_PDOWN: begin
        if (cke) begin
          modeD = MODE_NORMAL;
          cmdD  = CMD_PD_EXIT;
        end
      end
      MODE_SREF: begin
        if (cke) begin
          if (csN || idlePat) begin
            modeD = MODE_NORMAL;
            cmdD  = CMD_SREF_EXIT;
          end else begin
            illegalD = 1'b1;
          end
        end
      end
      default: modeD = MODE_NORMAL;
    endcase
  end

  always_comb begin
    strobe.captureDqm = (modeQ == MODE_NORMAL);
    strobe.clkRun     = (modeD == MODE_NORMAL);
    strobe.bufOn      = (modeD == MODE_NORMAL) || (modeD == MODE_SUSPEND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_NORMAL;
      cmdQ     <= CMD_NOP;
      illegalQ <= 1'b0;
      ckePrevQ <= 1'b1;
    end else begin
      modeQ    <= modeD;
      cmdQ     <= cmdD;
      illegalQ <= illegalD;
      ckePrevQ <= cke;
    end
  end

endmodule

// File: rtl/sdram_cmd_dp.sv
module sdram_cmd_dp
  import sdram_cmd_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] dqm,
  input  logic             burstActive,
  input  logic             burstWrite,
  input  dpStrobe_t        strobe,
  output logic [LANES-1:0] wrMask,
  output logic [LANES-1:0] rdDrive,
  output logic             intClkEn,
  output logic             bufEn
);

  logic wrSel;
  logic rdSel;

  assign wrSel = burstActive && burstWrite;
  assign rdSel = burstActive && !burstWrite;

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrMask[lane]  <= 1'b0;
        rdDrive[lane] <= 1'b0;
      end else if (strobe.captureDqm) begin
        wrMask[lane]  <= wrSel && dqm[lane];
        rdDrive[lane] <= rdSel && !dqm[lane];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intClkEn <= 1'b1;
      bufEn    <= 1'b1;
    end else begin
      intClkEn <= strobe.clkRun;
      bufEn    <= strobe.bufOn;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             cke,
  input  logic [LANES-1:0] dqm,
  input  logic             banksIdle,
  input  logic             burstActive,
  input  logic             burstWrite,
  output logic [3:0]       cmd,
  output logic [1:0]       mode,
  output logic             illegalCmd,
  output logic             intClkEn,
  output logic             bufEn,
  output logic [LANES-1:0] wrMask,
  output logic [LANES-1:0] rdDrive
);

  opMode_t   modeQ;
  cmdKind_t  cmdQ;
  dpStrobe_t strobe;

  sdram_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .banksIdle(banksIdle), .burstActive(burstActive),
    .modeQ(modeQ), .cmdQ(cmdQ), .illegalQ(illegalCmd), .strobe(strobe)
  );

  sdram_cmd_dp #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .dqm(dqm), .burstActive(burstActive),
    .burstWrite(burstWrite), .strobe(strobe), .wrMask(wrMask),
    .rdDrive(rdDrive), .intClkEn(intClkEn), .bufEn(bufEn)
  );

  assign cmd  = cmdQ;
  assign mode = modeQ;

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic             cke,
  input logic             banksIdle,
  input logic             burstActive,
  input logic [3:0]       cmd,
  input logic [1:0]       mode,
  input logic             illegalCmd,
  input logic             intClkEn,
  input logic             bufEn,
  input logic [LANES-1:0] wrMask,
  input logic [LANES-1:0] rdDrive
);

  logic refPat;
  assign refPat = !csN && !rasN && !casN && weN;

  assert_desel_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && cke && csN) |=> (cmd == 4'd1 && mode == 2'd0));

  assert_aref_ok_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && cke && refPat && banksIdle) |=> (cmd == 4'd2 && !illegalCmd));

  assert_sref_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && !cke) |=> (mode == 2'd3 && cmd == 4'd9));

  assert_sref_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && cke && csN) |=> (mode == 2'd0 && cmd == 4'd4));

  assert_susp_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && cke) |=> (mode == 2'd0 && intClkEn));

  assert_pd_enter_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && !cke && !burstActive && !refPat) |=> (mode == 2'd2 && !bufEn));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd0) |=> ($stable(wrMask) && $stable(rdDrive)));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .cke(cke), .banksIdle(banksIdle), .burstActive(burstActive), .cmd(cmd),
  .mode(mode), .illegalCmd(illegalCmd), .intClkEn(intClkEn), .bufEn(bufEn),
  .wrMask(wrMask), .rdDrive(rdDrive)
);

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;

  localparam int LANES = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1;
  logic [LANES-1:0] dqm = '0;
  logic banksIdle = 1'b1, burstActive = 1'b0, burstWrite = 1'b0;
  logic [3:0] cmd;
  logic [1:0] mode;
  logic illegalCmd, intClkEn, bufEn;
  logic [LANES-1:0] wrMask, rdDrive;

  int compared = 0;
  int mismatched = 0;

  // expected values
  int mMode, mCmd, mIll, mCkePrev;
  logic [LANES-1:0] mWr, mRd;

  always #10 clk = ~clk;

  sdram_cmd_tracker #(.LANES(LANES)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .dqm(dqm), .banksIdle(banksIdle), .burstActive(burstActive),
    .burstWrite(burstWrite), .cmd(cmd), .mode(mode), .illegalCmd(illegalCmd),
    .intClkEn(intClkEn), .bufEn(bufEn), .wrMask(wrMask), .rdDrive(rdDrive)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input int c, input int md);
    case (c)
      0, 1, 10: return "R2";
      2:        return "R3";
      3:        return "R4";
      4:        return "R5";
      5, 8:     return "R6";
      6, 7:     return "R7";
      default:  return (md == 3) ? "R4" : (md == 1) ? "R6" : "R7";
    endcase
  endfunction

  function automatic int expClk(input int md);
    return (md == 0) ? 1 : 0;
  endfunction

  function automatic int expBuf(input int md);
    return (md <= 1) ? 1 : 0;
  endfunction

  // reference step computed from the requirement text
  task automatic modelStep();
    int nm, nc, ni;
    logic rp, ip;
    rp = !rasN && !casN && weN;
    ip = rasN && casN && weN;
    nm = mMode; nc = 9; ni = 0;
    if (mMode == 0) begin
      if (!cke) begin
        if (!csN && rp) begin nm = 3; nc = 3; end
        else if (burstActive) begin nm = 1; nc = 5; end
        else begin nm = 2; nc = 6; end
      end else if (csN) nc = 1;
      else if (rp && mCkePrev == 1) begin nc = 2; ni = banksIdle ? 0 : 1; end
      else if (ip) nc = 0;
      else nc = 10;
      for (int l = 0; l < LANES; l++) begin
        mWr[l] = burstActive && burstWrite && dqm[l];
        mRd[l] = burstActive && !burstWrite && !dqm[l];
      end
    end else if (mMode == 1) begin
      if (cke) begin nm = 0; nc = 8; end
    end else if (mMode == 2) begin
      if (cke) begin nm = 0; nc = 7; end
    end else begin
      if (cke) begin
        if (csN || ip) begin nm = 0; nc = 4; end
        else ni = 1;
      end
    end
    mMode = nm; mCmd = nc; mIll = ni; mCkePrev = cke;
  endtask

  task automatic checkAll();
    string t;
    t = tagOf(mCmd, mMode);
    chk(t, "cmd", cmd, mCmd);
    chk(t, "mode", mode, mMode);
    chk((mCmd == 2) ? "R3" : "R5", "illegalCmd", illegalCmd, mIll);
    chk("R6", "intClkEn", intClkEn, expClk(mMode));
    chk("R7", "bufEn", bufEn, expBuf(mMode));
    chk("R8", "wrMask", wrMask, mWr);
    chk("R8", "rdDrive", rdDrive, mRd);
  endtask

  // drive at negedge, compare at the following negedge
  task automatic step(input logic c, input logic r, input logic a, input logic w,
                      input logic k, input logic [LANES-1:0] d,
                      input logic ba, input logic bw, input logic bi);
    csN = c; rasN = r; casN = a; weN = w; cke = k; dqm = d;
    burstActive = ba; burstWrite = bw; banksIdle = bi;
    modelStep();
    @(negedge clk);
    checkAll();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    mMode = 0; mCmd = 0; mIll = 0; mCkePrev = 1; mWr = '0; mRd = '0;
    repeat (3) @(negedge clk);
    // R1: reset state with pins wiggling
    csN = 1'b0; rasN = 1'b0; casN = 1'b0; weN = 1'b1; cke = 1'b0; dqm = '1;
    @(negedge clk);
    chk("R1", "mode", mode, 0);
    chk("R1", "cmd", cmd, 0);
    chk("R1", "intClkEn", intClkEn, 1);
    chk("R1", "bufEn", bufEn, 1);
    chk("R1", "illegalCmd", illegalCmd, 0);
    chk("R1", "wrMask", wrMask, 0);
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; cke = 1'b1; dqm = '0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "mode", mode, 0);

    // R2: deselect masks the command pins
    step(1, 0, 0, 1, 1, 2'b00, 0, 0, 1);
    step(0, 1, 1, 1, 1, 2'b00, 0, 0, 1);
    step(0, 0, 1, 0, 1, 2'b00, 0, 0, 1);
    // R3: refresh accepted / rejected
    step(0, 0, 0, 1, 1, 2'b00, 0, 0, 1);
    step(0, 0, 0, 1, 1, 2'b00, 0, 0, 0);
    // R4: self refresh entry, pins ignored while low
    step(0, 0, 0, 1, 0, 2'b11, 1, 1, 1);
    step(0, 0, 0, 0, 0, 2'b01, 1, 0, 1);
    // R5: bad exit then good exit
    step(0, 0, 1, 1, 1, 2'b00, 0, 0, 1);
    step(0, 1, 1, 1, 1, 2'b00, 0, 0, 1);
    step(1, 0, 0, 0, 0, 2'b00, 0, 0, 1);
    step(1, 0, 0, 0, 1, 2'b00, 0, 0, 1);
    // R6: suspend during write burst, dqm frozen (R8)
    step(0, 1, 1, 1, 1, 2'b10, 1, 1, 0);
    step(1, 1, 1, 1, 0, 2'b01, 1, 1, 0);
    step(1, 1, 1, 1, 0, 2'b11, 1, 0, 0);
    step(1, 1, 1, 1, 1, 2'b00, 1, 0, 0);
    // R7: power-down with no burst
    step(0, 1, 0, 1, 0, 2'b00, 0, 0, 1);
    step(1, 1, 1, 1, 0, 2'b11, 1, 1, 1);
    step(1, 1, 1, 1, 1, 2'b01, 1, 0, 1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic k;
      if (mMode == 0) k = ($urandom_range(0, 9) != 0);
      else            k = ($urandom_range(0, 3) == 0);
      step(($urandom_range(0, 2) == 0), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), k, LANES'($urandom), $urandom_range(0, 1),
           $urandom_range(0, 1), ($urandom_range(0, 3) != 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule